// File: doc/BRIEF.md
# Serial Port Clock and Frame-Sync Generator

This block produces the bit clock and the frame-sync pulse for a synchronous serial port. It runs entirely in the system clock domain. The input clock can be an internal source or one of several external clock pins. An external pin is brought in through a two-stage synchronizer, and its edges become single-cycle events. A state machine counts these events into a generated clock with a 50 % duty cycle. A frame counter, stepped once per generated clock cycle, shapes the frame-sync pulse.

The internal source gives an input clock at half the system clock rate. It produces one half-cycle event on every system cycle.

The input clock period counts as two half-cycle events. Each external pin has a polarity bit that chooses which of its edges counts as the active edge. A new high phase of the generated clock always starts on an active edge. In resynchronisation mode, a rising edge on an external frame-sync input sends the state machine back to alignment. The clock and the frame then restart on the next active edge.

The transmit frame sync is taken either from the generated pulse or from a transmitter-activity strobe, as chosen by a mode input.

States of the clock state machine:
- `ST_OFF`: disabled. Clock low, frame sync inactive.
- `ST_ALIGN`: waits for an active input edge.
- `ST_HIGH`: high phase of the generated clock.
- `ST_LOW`: low phase of the generated clock.

Transitions:
- T_ENABLE: `ST_OFF`→`ST_ALIGN` when enabled.
- T_LOCK: `ST_ALIGN`→`ST_HIGH` on an active edge. Starts a frame.
- T_HALF: `ST_HIGH`→`ST_LOW` after divide+1 events.
- T_WRAP: `ST_LOW`→`ST_HIGH` after divide+1 events. Steps the frame.
- T_RESYNC: any running state→`ST_ALIGN` on an accepted frame-sync edge.
- T_DISABLE: any state→`ST_OFF` when the enable input is low.

Top module: `serial_clkfs_gen`

## Requirements
- R1: While `rst` is high, or one cycle after `en` is sampled low, `clkg` and `fsg` are 0.
- R2: With `src_sel` = 0 (the internal source), `clkg` has a period of 2·(`div`+1) system cycles. It is high for the first `div`+1 of them.
- R3: `src_sel` = k (1..NUM_EXT) selects `ext_ck[k-1]`. `clkg` then has a period of `div`+1 periods of that pin. Its high and low phases each last `div`+1 pin half-periods.
- R4: `ext_fall[k-1]` = 0 makes the rising pin edge active; 1 makes the falling edge active. With `div` = 0, `clkg` equals the pin (or its inverse when falling is active), delayed by three system cycles.
- R5: `fsg` changes only when `clkg` rises. It is 1 during CLKG cycles 0..`frm_width` of each frame of `frm_period`+1 CLKG cycles. If `frm_width` ≥ `frm_period`, it stays 1.
- R6: One cycle after `en` is raised (internal source), `clkg` is still 0. One cycle later, `clkg` and `fsg` are both 1, which is the start of frame cycle 0.
- R7: With `sync_en` = 1, a rising edge on `ext_fs` drives `clkg` and `fsg` to 0 three cycles later. On the internal source, both go to 1 in the following cycle as a new frame. With `sync_en` = 0, `ext_fs` has no effect on the clock phase.
- R8: `tx_fs` follows `tx_strobe` when `tx_fs_mode` = 1, and follows `fsg` when `tx_fs_mode` = 0, in the same cycle.
- R9: Activity on external pins that are not selected does not change `clkg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Generator enable |
| src_sel | input | SEL_W | Input clock source: 0 internal, k selects ext_ck[k-1] |
| ext_ck | input | NUM_EXT | External clock pins |
| ext_fall | input | NUM_EXT | Per-pin active-edge select, 1 = falling |
| div | input | DIV_W | Clock divide value |
| frm_width | input | FRM_W | Frame-sync width minus one, in CLKG cycles |
| frm_period | input | FRM_W | Frame period minus one, in CLKG cycles |
| sync_en | input | 1 | Enable re-phasing on ext_fs rising edges |
| ext_fs | input | 1 | External frame-sync input |
| tx_fs_mode | input | 1 | Transmit frame-sync source: 0 generator, 1 strobe |
| tx_strobe | input | 1 | Transmitter-activity strobe |
| clkg | output | 1 | Generated clock, registered |
| fsg | output | 1 | Generated frame sync, registered |
| tx_fs | output | 1 | Transmit frame sync |

## Verification
The bench builds the block with DIV_W = 4, FRM_W = 4 and three external pins.

With these widths, a sweep of every divide value from 0 to 4 is short. It runs against every frame period from 0 to 4 and every width up to one beyond the period, so the always-asserted case is included. Each point is compared cycle by cycle with waveforms computed arithmetically.

The narrow fields also leave time to measure clock periods on each external pin. The bench checks both edge polarities against a delayed copy of the pin. It fires resync edges with the mode on and off, and toggles unselected pins.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ALIGN = 2'd1,
        ST_HIGH  = 2'd2,
        ST_LOW   = 2'd3
    } gen_state_t;

    typedef struct packed {
        logic ev;
        logic act;
    } src_evt_t;

endpackage

// File: rtl/sfg_edge_sync.sv
module sfg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic chg
);

    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            last  <= chain[STAGES-1];
        end
    end

    assign lvl = chain[STAGES-1];
    assign chg = chain[STAGES-1] ^ last;

endmodule

// File: rtl/sfg_src_sel.sv
module sfg_src_sel
    import sfg_pkg::*;
#(
    parameter int NUM_EXT = 3,
    parameter int SEL_W   = $clog2(NUM_EXT + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EXT-1:0] ext_ck,
    input  logic [NUM_EXT-1:0] ext_fall,
    input  logic [SEL_W-1:0]   sel,
    output src_evt_t           evt
);

    logic [NUM_EXT:0] ev_v;
    logic [NUM_EXT:0] act_v;

    // Internal source: one half-cycle event per system cycle, always usable for alignment.
    assign ev_v[0]  = 1'b1;
    assign act_v[0] = 1'b1;

    for (genvar g = 0; g < NUM_EXT; g++) begin : g_pin
        logic lvl_g;
        logic chg_g;

        sfg_edge_sync #(.STAGES(2)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (ext_ck[g]),
            .lvl (lvl_g),
            .chg (chg_g)
        );

        assign ev_v[g+1]  = chg_g;
        assign act_v[g+1] = chg_g & (ext_fall[g] ? ~lvl_g : lvl_g);
    end

    always_comb begin
        evt = '0;
        if (32'(sel) <= NUM_EXT) begin
            evt.ev  = ev_v[sel];
            evt.act = act_v[sel];
        end
    end

endmodule

// File: rtl/sfg_clk_fsm.sv
module sfg_clk_fsm
    import sfg_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             resync,
    input  logic             ev,
    input  logic             act,
    input  logic [DIV_W-1:0] div,
    output logic             clkg,
    output logic             frm_start,
    output logic             frm_step,
    output logic             frm_hold
);

    gen_state_t       st, st_nxt;
    logic [DIV_W-1:0] cnt, cnt_nxt;

    always_comb begin
        st_nxt    = st;
        cnt_nxt   = cnt;
        frm_start = 1'b0;
        frm_step  = 1'b0;
        if (!en) begin
            st_nxt  = ST_OFF;
            cnt_nxt = '0;
        end else if (resync && st != ST_OFF) begin
            st_nxt  = ST_ALIGN;
            cnt_nxt = '0;
        end else begin
            unique case (st)
                ST_OFF: begin
                    st_nxt  = ST_ALIGN;
                    cnt_nxt = '0;
                end
                ST_ALIGN: begin
                    if (ev && act) begin
                        st_nxt    = ST_HIGH;
                        cnt_nxt   = '0;
                        frm_start = 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (ev) begin
                        if (cnt >= div) begin
                            st_nxt  = ST_LOW;
                            cnt_nxt = '0;
                        end else begin
                            cnt_nxt = cnt + 1'b1;
                        end
                    end
                end
                ST_LOW: begin
                    if (ev) begin
                        if (cnt >= div) begin
                            st_nxt   = ST_HIGH;
                            cnt_nxt  = '0;
                            frm_step = 1'b1;
                        end else begin
                            cnt_nxt = cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    st_nxt  = ST_OFF;
                    cnt_nxt = '0;
                end
            endcase
        end
    end

    assign frm_hold = (st_nxt == ST_OFF) || (st_nxt == ST_ALIGN);

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_OFF;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (rst) begin
            clkg <= 1'b0;
        end else begin
            clkg <= (st_nxt == ST_HIGH);
        end
    end

    // R1
    clkg_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !clkg);

    // R3
    clkg_evt_chk: assert property (@(posedge clk) disable iff (rst)
        (clkg != $past(clkg)) |-> ($past(ev) || !$past(en) || $past(resync)));

endmodule

// File: rtl/sfg_frame_cnt.sv
module sfg_frame_cnt #(
    parameter int FRM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             start,
    input  logic             step,
    input  logic [FRM_W-1:0] fwid,
    input  logic [FRM_W-1:0] fper,
    output logic             fsg
);

    logic [FRM_W-1:0] fcnt, fcnt_nxt;

    always_comb begin
        fcnt_nxt = fcnt;
        if (hold || start) begin
            fcnt_nxt = '0;
        end else if (step) begin
            fcnt_nxt = (fcnt >= fper) ? '0 : fcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fcnt <= '0;
            fsg  <= 1'b0;
        end else begin
            fcnt <= fcnt_nxt;
            if (hold) begin
                fsg <= 1'b0;
            end else if (start || step) begin
                fsg <= (fcnt_nxt <= fwid);
            end
        end
    end

    // R5
    fsg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> !fsg);

    // R6
    fsg_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !hold) |=> fsg);

endmodule

// File: rtl/serial_clkfs_gen.sv
module serial_clkfs_gen
    import sfg_pkg::*;
#(
    parameter int NUM_EXT = 3,
    parameter int DIV_W   = 8,
    parameter int FRM_W   = 12,
    parameter int SEL_W   = $clog2(NUM_EXT + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic [NUM_EXT-1:0] ext_ck,
    input  logic [NUM_EXT-1:0] ext_fall,
    input  logic [DIV_W-1:0]   div,
    input  logic [FRM_W-1:0]   frm_width,
    input  logic [FRM_W-1:0]   frm_period,
    input  logic               sync_en,
    input  logic               ext_fs,
    input  logic               tx_fs_mode,
    input  logic               tx_strobe,
    output logic               clkg,
    output logic               fsg,
    output logic               tx_fs
);

    src_evt_t evt;
    logic     fs_lvl, fs_chg, resync;
    logic     frm_start, frm_step, frm_hold;

    sfg_src_sel #(.NUM_EXT(NUM_EXT), .SEL_W(SEL_W)) u_src (
        .clk      (clk),
        .rst      (rst),
        .ext_ck   (ext_ck),
        .ext_fall (ext_fall),
        .sel      (src_sel),
        .evt      (evt)
    );

    sfg_edge_sync #(.STAGES(2)) u_fs_sync (
        .clk (clk),
        .rst (rst),
        .din (ext_fs),
        .lvl (fs_lvl),
        .chg (fs_chg)
    );

    assign resync = sync_en & fs_chg & fs_lvl;

    sfg_clk_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .resync    (resync),
        .ev        (evt.ev),
        .act       (evt.act),
        .div       (div),
        .clkg      (clkg),
        .frm_start (frm_start),
        .frm_step  (frm_step),
        .frm_hold  (frm_hold)
    );

    sfg_frame_cnt #(.FRM_W(FRM_W)) u_frm (
        .clk   (clk),
        .rst   (rst),
        .hold  (frm_hold),
        .start (frm_start),
        .step  (frm_step),
        .fwid  (frm_width),
        .fper  (frm_period),
        .fsg   (fsg)
    );

    assign tx_fs = tx_fs_mode ? tx_strobe : fsg;

    // R5
    fsg_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fsg) |-> $rose(clkg));

endmodule

// File: tb/serial_clkfs_gen_bench.sv
`timescale 1ns/1ps
module serial_clkfs_gen_bench;

    localparam int NE = 3;
    localparam int DW = 4;
    localparam int FW = 4;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic [SW-1:0] sel = '0;
    logic [NE-1:0] man_ck = '0;
    logic          gen_ck = 1'b0;
    logic          tog_on = 1'b0;
    int            tog_idx = 0;
    int            tog_half = 2;
    int            tog_cnt = 0;
    logic [NE-1:0] ext_ck;
    logic [NE-1:0] ext_fall = '0;
    logic [DW-1:0] div = '0;
    logic [FW-1:0] fw = '0;
    logic [FW-1:0] fp = '0;
    logic          sync_en = 1'b0;
    logic          ext_fs = 1'b0;
    logic          mode = 1'b0;
    logic          strobe = 1'b0;
    logic          clkg, fsg, tx_fs;
    logic          h0 = 1'b0, h1 = 1'b0, h2 = 1'b0;
    int            total = 0;
    int            bad = 0;

    always #4 clk = ~clk;

    always_comb begin
        ext_ck = man_ck;
        if (tog_on) ext_ck[tog_idx] = gen_ck;
    end

    always @(negedge clk) begin
        if (tog_on) begin
            if (tog_cnt >= tog_half - 1) begin
                tog_cnt = 0;
                gen_ck  = ~gen_ck;
            end else begin
                tog_cnt = tog_cnt + 1;
            end
        end
    end

    always @(posedge clk) begin
        h0 <= ext_ck[tog_idx];
        h1 <= h0;
        h2 <= h1;
    end

    serial_clkfs_gen #(.NUM_EXT(NE), .DIV_W(DW), .FRM_W(FW), .SEL_W(SW)) u_serial_clkfs_gen (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .src_sel    (sel),
        .ext_ck     (ext_ck),
        .ext_fall   (ext_fall),
        .div        (div),
        .frm_width  (fw),
        .frm_period (fp),
        .sync_en    (sync_en),
        .ext_fs     (ext_fs),
        .tx_fs_mode (mode),
        .tx_strobe  (strobe),
        .clkg       (clkg),
        .fsg        (fsg),
        .tx_fs      (tx_fs)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compares clkg/fsg against the arithmetic waveform, t = frame-relative cycle index.
    task automatic check_run(input int t0, input int n, input string req);
        int mc = 0;
        int mf = 0;
        int ac = 0, ec = 0, af = 0, ef = 0;
        for (int i = 0; i < n; i++) begin
            int t, half, cyc, xc, xf;
            @(negedge clk);
            t    = t0 + i;
            half = int'(div) + 1;
            cyc  = t / (2 * half);
            xc   = ((t / half) % 2) == 0;
            xf   = (cyc % (int'(fp) + 1)) <= int'(fw);
            if (int'(clkg) != xc) begin
                if (mc == 0) begin ac = clkg; ec = xc; end
                mc++;
            end
            if (int'(fsg) != xf) begin
                if (mf == 0) begin af = fsg; ef = xf; end
                mf++;
            end
        end
        chk(mc == 0, req, $sformatf("clkg waveform div=%0d (first bad value)", div), ac, ec);
        chk(mf == 0, "R5", $sformatf("fsg waveform div=%0d per=%0d wid=%0d", div, fp, fw), af, ef);
    endtask

    task automatic start_internal(input int d, input int p, input int w);
        @(negedge clk);
        en = 1'b0; sel = '0; tog_on = 1'b0;
        div = DW'(d); fp = FW'(p); fw = FW'(w);
        @(negedge clk);
        chk(clkg == 1'b0 && fsg == 1'b0, "R1", "clkg/fsg after en low", {clkg, fsg}, 0);
        en = 1'b1;
        @(negedge clk);
        chk(clkg == 1'b0, "R6", "clkg one cycle after enable", clkg, 0);
    endtask

    task automatic measure_ext(input int s, input int d, input int h, input string req);
        int prev, guard, hi, lo;
        @(negedge clk);
        en = 1'b0; sel = SW'(s); div = DW'(d); ext_fall = '0;
        tog_idx = s - 1; tog_half = h; tog_on = 1'b1;
        @(negedge clk);
        en = 1'b1;
        repeat (4 * (d + 1) * h + 8) @(negedge clk);
        guard = 0;
        do begin
            prev = clkg;
            @(negedge clk);
            guard++;
        end while (!(prev == 0 && clkg == 1'b1) && guard < 1000);
        hi = 0;
        while (clkg == 1'b1 && hi < 1000) begin hi++; @(negedge clk); end
        lo = 0;
        while (clkg == 1'b0 && lo < 1000) begin lo++; @(negedge clk); end
        chk(hi == (d + 1) * h, req, $sformatf("high phase pin%0d div=%0d", s, d), hi, (d + 1) * h);
        chk(lo == (d + 1) * h, req, $sformatf("low phase pin%0d div=%0d", s, d), lo, (d + 1) * h);
    endtask

    task automatic pol_check(input int s, input logic f);
        int mis = 0;
        int av = 0, ev = 0;
        @(negedge clk);
        en = 1'b0; sel = SW'(s); div = '0; ext_fall = '0; ext_fall[s-1] = f;
        tog_idx = s - 1; tog_half = 4; tog_on = 1'b1;
        @(negedge clk);
        en = 1'b1;
        repeat (20) @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (clkg != (h2 ^ f)) begin
                if (mis == 0) begin av = clkg; ev = h2 ^ f; end
                mis++;
            end
        end
        chk(mis == 0, "R4", $sformatf("clkg vs delayed pin%0d fall=%0d", s, f), av, ev);
    endtask

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(clkg == 1'b0 && fsg == 1'b0, "R1", "outputs in reset", {clkg, fsg}, 0);
        rst = 1'b0;

        // R2 R5 R6: sweep of divide, period and width on the internal source.
        for (int d = 0; d <= 4; d++) begin
            for (int p = 0; p <= 4; p++) begin
                for (int w = 0; w <= p + 1; w++) begin
                    start_internal(d, p, w);
                    check_run(0, 4 * (d + 1) * (p + 1) + 3, "R2");
                end
            end
        end

        // R1: disable while running.
        start_internal(1, 2, 0);
        check_run(0, 7, "R2");
        en = 1'b0;
        @(negedge clk);
        chk(clkg == 1'b0 && fsg == 1'b0, "R1", "outputs one cycle after en drop", {clkg, fsg}, 0);

        // R8: transmit frame-sync selection.
        start_internal(0, 3, 1);
        check_run(0, 3, "R2");
        begin
            int mis = 0;
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                #1;
                if (tx_fs != fsg) mis++;
            end
            chk(mis == 0, "R8", "tx_fs follows fsg in mode 0", mis, 0);
            mode = 1'b1;
            mis = 0;
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                strobe = i[0] ^ i[2];
                #1;
                if (tx_fs != strobe) mis++;
            end
            chk(mis == 0, "R8", "tx_fs follows strobe in mode 1", mis, 0);
            mode = 1'b0;
            strobe = 1'b0;
        end

        // R7: resync on external frame-sync edge.
        start_internal(1, 3, 1);
        check_run(0, 9, "R2");
        sync_en = 1'b1;
        ext_fs  = 1'b1;
        repeat (3) @(negedge clk);
        chk(clkg == 1'b0 && fsg == 1'b0, "R7", "outputs after resync edge", {clkg, fsg}, 0);
        check_run(0, 20, "R7");
        sync_en = 1'b0;
        ext_fs  = 1'b0;
        check_run(20, 10, "R7");
        ext_fs = 1'b1;
        check_run(30, 30, "R7");
        ext_fs = 1'b0;

        // R3: periods on each external pin.
        measure_ext(1, 0, 3, "R3");
        measure_ext(1, 2, 3, "R3");
        measure_ext(2, 1, 2, "R3");
        measure_ext(3, 3, 4, "R3");

        // R4: edge polarity.
        pol_check(1, 1'b0);
        pol_check(1, 1'b1);
        pol_check(3, 1'b1);

        // R9: unselected pins toggled, selected pin idle.
        @(negedge clk);
        en = 1'b0; tog_on = 1'b0; man_ck = '0; sel = SW'(1); div = '0; ext_fall = '0;
        @(negedge clk);
        en = 1'b1;
        repeat (10) @(negedge clk);
        begin
            int mis = 0;
            logic v;
            v = clkg;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (i % 2 == 0) man_ck[2:1] = ~man_ck[2:1];
                if (clkg != v) mis++;
            end
            chk(mis == 0, "R9", "clkg changes from unselected pins", mis, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule